// File: doc/BRIEF.md
# Fuse Array Sense and Program Controller

This block controls a small one-time-programmable fuse array, which is organised as banks of 32-bit words. The fuse array is modelled inside the block. Each fuse bit starts at 0 and can only ever change to 1. Software talks to the block over a simple synchronous register bus. A write is taken on the rising clock edge when `bus_we` is high. Read data is a combinational decode of `bus_addr`.

A word is picked by a 7-bit target index, equal to bank times 8 plus the word within the bank. A write of 1 to the sense register starts a timed read of that word. A write to the data register starts a timed program cycle, which ORs the written value into the word. A program cycle runs only after software has loaded the 16-bit unlock value 3E77h into the control register. Each word also has a shadow register. Software can read it and can overwrite it, and neither action touches the fuse bits. Strobe and relax intervals come from a timing register and are counted in clock cycles. An error flag records refused requests and is cleared through a clear alias of the control register.

Register word addresses on `bus_addr`:

| Address | Register |
|---|---|
| 000h | control |
| 001h | clear alias |
| 002h | timing |
| 003h | data |
| 004h | sense |
| 005h | sensed data |
| 100h + index | shadow registers |

Top module: `otp_ctrl`

## Requirements
- R1: After reset the control register reads 0, the timing register reads 0008_1064h (read strobe 8, relax 1, program strobe 100), the sensed-data register reads 0, and every shadow register reads 0.
- R2: The control register (address 000h) holds the unlock field in bits 31:16, the error flag in bit 9, the busy flag in bit 8 and the target index in bits 6:0. The target index is bank*8+word. Bus writes cannot change bits 9 and 8, and all other bits read 0.
- R3: A write with bit 0 set to the sense register (004h) makes busy read 1 for 2*(relax+1)+(read strobe+1) cycles. When busy clears, the sensed-data register (005h) holds the fuse word at the target index.
- R4: When the unlock field holds 3E77h, a write to the data register (003h) makes busy read 1 for 2*(relax+1)+(program strobe+1) cycles. At the end of that cycle the written value has been ORed into the target fuse word, and the unlock field reads 0.
- R5: When the unlock field does not hold 3E77h, a data-register write programs nothing, leaves busy at 0, and sets the error flag.
- R6: A sense or data-register request made while busy is 1 is ignored: the running operation and its result are unchanged, and the error flag is set.
- R7: Writing the clear alias (001h) clears every bit among 31:16, 9 and 6:0 whose written bit is 1, and leaves the bits written as 0 unchanged. Writing 1 to bit 9 clears the error flag.
- R8: The timing register (002h) holds the read strobe in bits 21:16, the relax count in bits 15:12 and the program strobe in bits 11:0, and bits 31:22 read 0. A new value changes the busy durations of R3 and R4 accordingly.
- R9: The shadow register of index i sits at 100h+i and can be read and written directly. Writing it does not change the fuse word, and programming does not change it.
- R10: Fuse bits are sticky: a second program cycle on the same word leaves the OR of both values.
- R11: The sense register, unmapped addresses and shadow addresses at or beyond the array size read 0.
- R12: A sense or program request whose target index is at or beyond NBANK*NWORD is ignored and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The bench builds the block with NBANK=4 and NWORD=8, which gives 32 fuse words. With that size, target indices 32 to 127 fit in the 7-bit field but fall outside the array, so the out-of-range refusal path and the zero reads of absent shadows can be reached. The default timing is kept for the exact busy-length checks. A short timing value is then loaded, which shows that the durations follow the register and keeps the busy-collision tests brief.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 7;
    localparam int BUS_AW   = 9;
    localparam int CNT_W    = 12;

    localparam logic [15:0] UNLOCK_VALUE = 16'h3E77;

    localparam logic [BUS_AW-1:0] REG_CTRL    = 9'h000;
    localparam logic [BUS_AW-1:0] REG_CLR     = 9'h001;
    localparam logic [BUS_AW-1:0] REG_TIMING  = 9'h002;
    localparam logic [BUS_AW-1:0] REG_DATA    = 9'h003;
    localparam logic [BUS_AW-1:0] REG_SENSE   = 9'h004;
    localparam logic [BUS_AW-1:0] REG_SENSED  = 9'h005;
    localparam logic [1:0]        SHADOW_SEL  = 2'b10;

    localparam int ERR_BIT  = 9;
    localparam int BUSY_BIT = 8;

    typedef struct packed {
        logic [5:0]  rd_strobe;
        logic [3:0]  relax;
        logic [11:0] pg_strobe;
    } timing_t;

    typedef enum logic {
        OP_SENSE = 1'b0,
        OP_PROG  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_STROBE,
        PH_POST
    } phase_e;

    typedef struct packed {
        op_e               op;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } req_t;

    localparam timing_t TIMING_RST = '{rd_strobe: 6'd8, relax: 4'd1, pg_strobe: 12'd100};

    function automatic timing_t timing_unpack(input logic [DATA_W-1:0] w);
        timing_unpack = '{rd_strobe: w[21:16], relax: w[15:12], pg_strobe: w[11:0]};
    endfunction

    function automatic logic [DATA_W-1:0] timing_pack(input timing_t t);
        timing_pack = {10'b0, t.rd_strobe, t.relax, t.pg_strobe};
    endfunction

    function automatic logic [CNT_W-1:0] strobe_len(input timing_t t, input op_e op);
        strobe_len = (op == OP_PROG) ? t.pg_strobe : {6'b0, t.rd_strobe};
    endfunction

endpackage

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  req_t    req,
    input  timing_t timing,
    output logic    busy,
    output logic    commit,
    output req_t    held
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    timing_t          tmg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tmg_q   <= TIMING_RST;
            held    <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        held    <= req;
                        tmg_q   <= timing;
                        cnt_q   <= {8'b0, timing.relax};
                        phase_q <= PH_PRE;
                    end
                end
                PH_PRE: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= strobe_len(tmg_q, held.op);
                        phase_q <= PH_STROBE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= {8'b0, tmg_q.relax};
                        phase_q <= PH_POST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy   = (phase_q != PH_IDLE);
    assign commit = (phase_q == PH_POST) && (cnt_q == '0);

endmodule

// File: rtl/otp_array.sv
module otp_array
    import otp_pkg::*;
#(
    parameter int NWORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [IDX_W-1:0]  sense_idx,
    output logic [DATA_W-1:0] sense_data,
    input  logic              shw_we,
    input  logic [IDX_W-1:0]  shw_idx,
    input  logic [DATA_W-1:0] shw_wdata,
    output logic [DATA_W-1:0] shw_rdata
);

    logic [DATA_W-1:0] fuse_q   [NWORDS];
    logic [DATA_W-1:0] shadow_q [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                fuse_q[i]   <= '0;
                shadow_q[i] <= '0;
            end else begin
                if (prog_en && prog_idx == IDX_W'(i)) begin
                    fuse_q[i] <= fuse_q[i] | prog_data;
                end
                if (shw_we && shw_idx == IDX_W'(i)) begin
                    shadow_q[i] <= shw_wdata;
                end
            end
        end
    end

    always_comb begin
        sense_data = '0;
        shw_rdata  = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (sense_idx == IDX_W'(i)) sense_data = fuse_q[i];
            if (shw_idx == IDX_W'(i))   shw_rdata  = shadow_q[i];
        end
    end

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int NBANK = 16,
    parameter int NWORD = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [8:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int         NFUSE   = NBANK * NWORD;
    localparam logic [7:0] NFUSE_L = 8'(NFUSE);

    logic [15:0]       key_q;
    logic [IDX_W-1:0]  idx_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] sensed_q;
    timing_t           timing_q;

    logic              busy;
    logic              commit;
    req_t              held;
    req_t              new_req;
    logic              start;
    logic [DATA_W-1:0] sense_data;
    logic [DATA_W-1:0] shw_rdata;

    logic wr_ctrl, wr_clr, wr_timing, wr_data, wr_sense;
    logic sense_req, prog_req, any_req, key_ok, idx_ok, err_set;
    logic shw_hit, shw_ok;

    assign wr_ctrl   = bus_we && bus_addr == REG_CTRL;
    assign wr_clr    = bus_we && bus_addr == REG_CLR;
    assign wr_timing = bus_we && bus_addr == REG_TIMING;
    assign wr_data   = bus_we && bus_addr == REG_DATA;
    assign wr_sense  = bus_we && bus_addr == REG_SENSE;

    assign shw_hit   = bus_addr[8:7] == SHADOW_SEL;
    assign shw_ok    = shw_hit && ({1'b0, bus_addr[6:0]} < NFUSE_L);

    assign sense_req = wr_sense && bus_wdata[0];
    assign prog_req  = wr_data;
    assign any_req   = sense_req || prog_req;
    assign key_ok    = key_q == UNLOCK_VALUE;
    assign idx_ok    = {1'b0, idx_q} < NFUSE_L;

    assign start     = !busy && idx_ok && (sense_req || (prog_req && key_ok));
    assign err_set   = any_req && (busy || !idx_ok || (prog_req && !key_ok));

    assign new_req   = '{op:   prog_req ? OP_PROG : OP_SENSE,
                         idx:  idx_q,
                         data: bus_wdata};

    otp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req    (new_req),
        .timing (timing_q),
        .busy   (busy),
        .commit (commit),
        .held   (held)
    );

    otp_array #(.NWORDS(NFUSE)) u_array (
        .clk        (clk),
        .rst        (rst),
        .prog_en    (commit && held.op == OP_PROG),
        .prog_idx   (held.idx),
        .prog_data  (held.data),
        .sense_idx  (held.idx),
        .sense_data (sense_data),
        .shw_we     (bus_we && shw_ok),
        .shw_idx    (bus_addr[6:0]),
        .shw_wdata  (bus_wdata),
        .shw_rdata  (shw_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= '0;
            idx_q    <= '0;
            err_q    <= 1'b0;
            data_q   <= '0;
            sensed_q <= '0;
            timing_q <= TIMING_RST;
        end else begin
            if (wr_ctrl) begin
                key_q <= bus_wdata[31:16];
                idx_q <= bus_wdata[IDX_W-1:0];
            end
            if (wr_clr) begin
                key_q <= key_q & ~bus_wdata[31:16];
                idx_q <= idx_q & ~bus_wdata[IDX_W-1:0];
            end
            if (err_set) begin
                err_q <= 1'b1;
            end else if (wr_clr && bus_wdata[ERR_BIT]) begin
                err_q <= 1'b0;
            end
            if (wr_timing) begin
                timing_q <= timing_unpack(bus_wdata);
            end
            if (wr_data && !busy) begin
                data_q <= bus_wdata;
            end
            if (commit && held.op == OP_SENSE) begin
                sensed_q <= sense_data;
            end
            if (commit && held.op == OP_PROG) begin
                key_q <= '0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL, REG_CLR: bus_rdata = {key_q, 6'b0, err_q, busy, 1'b0, idx_q};
            REG_TIMING:        bus_rdata = timing_pack(timing_q);
            REG_DATA:          bus_rdata = data_q;
            REG_SENSED:        bus_rdata = sensed_q;
            default:           bus_rdata = shw_ok ? shw_rdata : '0;
        endcase
    end

endmodule

// File: rtl/otp_ctrl_chk.sv
module otp_ctrl_chk
    import otp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        err,
    input logic [15:0] key,
    input logic        start,
    input logic        commit,
    input op_e         commit_op,
    input op_e         start_op,
    input timing_t     timing,
    input logic        bus_we,
    input logic [8:0]  bus_addr,
    input logic [31:0] bus_wdata
);

    logic [15:0] run_cnt;
    logic [15:0] run_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            run_exp <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 1'b1 : '0;
            if (start) begin
                run_exp <= 16'(2 * (timing.relax + 1))
                         + 16'(strobe_len(timing, start_op)) + 16'd1;
            end
        end
    end

    // R3
    seq_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_cnt == run_exp);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4
    key_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && commit_op == OP_PROG) |=> key == 16'h0);

    // R5
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_we && bus_addr == REG_DATA && key != UNLOCK_VALUE) |=> (err && !busy));

    // R6
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && (bus_addr == REG_DATA || (bus_addr == REG_SENSE && bus_wdata[0]))) |=> err);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(bus_we && bus_addr == REG_CLR && bus_wdata[ERR_BIT]));

endmodule

bind otp_ctrl otp_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .err       (err_q),
    .key       (key_q),
    .start     (start),
    .commit    (commit),
    .commit_op (held.op),
    .start_op  (new_req.op),
    .timing    (timing_q),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_otp_ctrl.sv
module sim_otp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] A_CTRL = 9'h000, A_CLR = 9'h001, A_TIM = 9'h002,
                           A_DATA = 9'h003, A_SENSE = 9'h004, A_SENSED = 9'h005,
                           A_SHW = 9'h100;
    localparam logic [15:0] KEY = 16'h3E77;

    // op: 0 program, 1 sense, 2 shadow write, 3 shadow read
    localparam int NVEC = 11;
    localparam logic [72:0] VEC [NVEC] = '{
        {2'd0, 7'd3,  32'h0000_00F0, 32'h0},
        {2'd1, 7'd3,  32'h0,         32'h0000_00F0},
        {2'd0, 7'd3,  32'h0000_0F0F, 32'h0},
        {2'd1, 7'd3,  32'h0,         32'h0000_0FFF},
        {2'd2, 7'd3,  32'hDEAD_BEEF, 32'h0},
        {2'd3, 7'd3,  32'h0,         32'hDEAD_BEEF},
        {2'd1, 7'd3,  32'h0,         32'h0000_0FFF},
        {2'd0, 7'd31, 32'h8000_0001, 32'h0},
        {2'd1, 7'd31, 32'h0,         32'h8000_0001},
        {2'd1, 7'd0,  32'h0,         32'h0},
        {2'd3, 7'd31, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_ctrl #(.NBANK(4), .NWORD(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic busy_now();
        busy_now = u0.bus_rdata[8] && (bus_addr == A_CTRL);
    endfunction

    task automatic busy_len(output int n);
        logic [31:0] v;
        n = 0;
        bus_addr = A_CTRL;
        #1 v = bus_rdata;
        while (v[8] && n < 5000) begin
            n++;
            @(negedge clk);
            #1 v = bus_rdata;
        end
    endtask

    task automatic do_prog(input logic [6:0] w, input logic [31:0] d, output int n);
        wr(A_CTRL, {KEY, 9'b0, w});
        wr(A_DATA, d);
        busy_len(n);
    endtask

    task automatic do_sense(input logic [6:0] w, output int n, output logic [31:0] v);
        wr(A_CTRL, {16'h0, 9'b0, w});
        wr(A_SENSE, 32'h1);
        busy_len(n);
        rd(A_SENSED, v);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        int n;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        rd(A_TIM, v);    chk("R1 timing", v, 32'h0008_1064);
        rd(A_SENSED, v); chk("R1 sensed", v, 32'h0);
        rd(A_SHW + 9'd5, v); chk("R1 shadow", v, 32'h0);

        // R11 zero reads
        rd(A_SENSE, v);  chk("R11 sense reg", v, 32'h0);
        rd(9'h050, v);   chk("R11 unmapped", v, 32'h0);
        rd(A_SHW + 9'd40, v); chk("R11 shadow beyond", v, 32'h0);

        // R2 field layout, bank 2 word 5 -> index 21
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v);   chk("R2 ctrl mask", v, 32'hFFFF_007F);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_CTRL, v);   chk("R7 clear all", v, 32'h0);
        wr(A_CTRL, {16'h0, 9'b0, 7'(2*8+5)});
        rd(A_CTRL, v);   chk("R2 bank/word index", v, 32'h0000_0015);

        // R4 default program duration, key wipe
        do_prog(7'd1, 32'h0000_00A5, n);
        chk("R4 program busy length", 32'(n), 32'd105);
        rd(A_CTRL, v);   chk("R4 key cleared", v, 32'h0000_0001);
        // R3 default sense duration
        do_sense(7'd1, n, v);
        chk("R3 sense value", v, 32'h0000_00A5);
        chk("R3 sense busy length", 32'(n), 32'd13);

        // table of vectors (R9, R10)
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [6:0]  w;
            logic [31:0] d, e, got;
            {op, w, d, e} = VEC[i];
            case (op)
                2'd0: do_prog(w, d, n);
                2'd1: begin
                    do_sense(w, n, got);
                    chk($sformatf("R10 vec %0d sense", i), got, e);
                end
                2'd2: wr(A_SHW + {2'b0, w}, d);
                default: begin
                    rd(A_SHW + {2'b0, w}, got);
                    chk($sformatf("R9 vec %0d shadow", i), got, e);
                end
            endcase
        end

        // R8 timing fields and durations
        wr(A_TIM, 32'hFFC2_0005);
        rd(A_TIM, v);    chk("R8 timing readback", v, 32'h0002_0005);
        do_sense(7'd3, n, v);
        chk("R8 short sense length", 32'(n), 32'd5);
        do_prog(7'd4, 32'h0000_0001, n);
        chk("R8 short program length", 32'(n), 32'd8);

        // R5 wrong key
        wr(A_CTRL, {16'h1234, 9'b0, 7'd5});
        wr(A_DATA, 32'h0000_00FF);
        rd(A_CTRL, v);   chk("R5 error, not busy", v, 32'h1234_0205);
        // R7 zero write leaves error
        wr(A_CLR, 32'h0);
        rd(A_CTRL, v);   chk("R7 zero clear no effect", v, 32'h1234_0205);
        wr(A_CLR, 32'h0000_0200);
        rd(A_CTRL, v);   chk("R7 error cleared", v, 32'h1234_0005);
        do_sense(7'd5, n, v);
        chk("R5 word not programmed", v, 32'h0);

        // R6 requests while busy
        wr(A_CTRL, {KEY, 9'b0, 7'd3});
        wr(A_SENSE, 32'h1);
        wr(A_SENSE, 32'h1);
        wr(A_DATA, 32'hF000_0000);
        busy_len(n);
        rd(A_CTRL, v);   chk("R6 error set, key kept", v, 32'h3E77_0203);
        rd(A_SENSED, v); chk("R6 sense result intact", v, 32'h0000_0FFF);
        wr(A_CLR, 32'hFFFF_0200);
        do_sense(7'd3, n, v);
        chk("R6 busy write did not program", v, 32'h0000_0FFF);

        // R12 target beyond array
        wr(A_CTRL, {16'h0, 9'b0, 7'd40});
        wr(A_SENSE, 32'h1);
        rd(A_CTRL, v);   chk("R12 out of range sense", v, 32'h0000_0228);
        wr(A_CLR, 32'h0000_0200);
        wr(A_CTRL, {KEY, 9'b0, 7'd40});
        wr(A_DATA, 32'h1);
        rd(A_CTRL, v);   chk("R12 out of range program", v, 32'h3E77_0228);

        report();
    end

endmodule